// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, one destination address at a time, whether an incoming Ethernet frame should be kept. The six bytes of the destination address arrive one per cycle on a byte stream with a valid strobe. A separate input marks the first byte. One cycle after the sixth byte the block raises a one-cycle result strobe. With it come an accept bit and a flag that says whether the address was a group (multicast) address.

The filter holds a 48-bit station address in two write-only registers. It also holds a 64-bit multicast hash table in two 32-bit registers, and a mode register with four enables: broadcast, all-multicast, promiscuous and hash-multicast. While the bytes stream in, a reflected CRC-32 is computed over them, one byte per cycle. The top six bits of that CRC select one bit of the hash table. Parsing the rest of the frame, checking the FCS and moving data are handled elsewhere.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `resultValid`, `accept` and `isMcast` are 0. The mode register holds broadcast enable = 1 and every other enable = 0. The station address and the hash table are all zeros.
- R2: `resultValid` is high for exactly one cycle, the cycle after the sixth address byte is taken. While `resultValid` is low, `accept` and `isMcast` are 0.
- R3: A byte taken with `daFirst` = 1 is address byte 0, which drops any partly received address. Without `daFirst`, each valid byte advances the byte position; gaps without `byteValid` are allowed between bytes.
- R4: Register map, written through `regWrEn`/`regAddr`/`regWrData`:
  - address 0 is the mode register: bit 0 broadcast enable, bit 1 all-multicast, bit 2 promiscuous, bit 3 hash enable.
  - address 1 holds address byte 0 in bits 15:8 and byte 1 in bits 7:0.
  - address 2 holds byte 2 in bits 31:24, byte 3 in 23:16, byte 4 in 15:8 and byte 5 in 7:0.
  - addresses 3 and 4 are hash table words 0 and 1.

  A unicast address is accepted only when all 48 bits equal the station address.
- R5: `isMcast` equals bit 0 of address byte 0, the first byte received; broadcast counts as multicast.
- R6: The all-ones address is accepted when broadcast enable is set; all-multicast and the hash table have no effect on it.
- R7: With all-multicast set, every multicast address that is not broadcast is accepted.
- R8: The hash index is bits 31:26 of a reflected CRC-32 (polynomial 0xEDB88320, preset all ones, no final inversion) over the six bytes in arrival order. Index 32..63 selects bit index−32 of hash word 1, and index 0..31 selects bit index of hash word 0. A set bit accepts a non-broadcast multicast address, but only while hash enable is 1.
- R9: With promiscuous set, every address is accepted.
- R10: A register write in the same cycle as the sixth byte does not affect that decision. The decision uses the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| byteValid | input | 1 | Address byte present on `byteData` |
| daFirst | input | 1 | Marks the current byte as address byte 0 |
| byteData | input | 8 | Destination address byte |
| resultValid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame is to be kept |
| isMcast | output | 1 | Destination is a group address |

## Verification
Assertions check on every cycle that the result strobe follows an accepted byte and never lasts two cycles. They also check that the outputs stay quiet while no result is presented, and that promiscuous mode always yields an accept. The bench scenarios are needed for everything else:
- the exact station match,
- the CRC-derived hash index and which register half it selects,
- broadcast handling with the enable cleared,
- resynchronisation on `daFirst`,
- a write that lands on the deciding cycle and must not affect that decision.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int SLOT_W     = $clog2(ADDR_BYTES);
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic bcastEn;
    logic allMcast;
    logic promisc;
    logic hashEn;
  } mode_t;

  typedef struct packed {
    logic              step;
    logic              seed;
    logic              finish;
    logic [SLOT_W-1:0] slot;
  } dpCtl_t;

  // one byte of a reflected CRC, least significant bit first
  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-8){1'b0}}, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_dest_filter_regs.sv
module rx_dest_filter_regs
  import rx_dest_filter_pkg::*;
#(
  parameter int HASH_IDX_W = 6,
  parameter int REG_W      = 32,
  parameter int REG_ADDR_W = 3,
  localparam int HASH_BITS = 1 << HASH_IDX_W,
  localparam int HASH_REGS = HASH_BITS / REG_W,
  localparam int HASH_BASE = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]      wrData,
  output mode_t                 modeQ,
  output logic [ADDR_W-1:0]     stationQ,
  output logic [HASH_BITS-1:0]  hashQ
);
  localparam int HI_W = ADDR_W - REG_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= '{bcastEn: 1'b1, allMcast: 1'b0, promisc: 1'b0, hashEn: 1'b0};
      stationQ <= '0;
      hashQ    <= '0;
    end else if (wrEn) begin
      if (wrAddr == REG_ADDR_W'(0)) begin
        modeQ.bcastEn  <= wrData[0];
        modeQ.allMcast <= wrData[1];
        modeQ.promisc  <= wrData[2];
        modeQ.hashEn   <= wrData[3];
      end
      if (wrAddr == REG_ADDR_W'(1)) stationQ[ADDR_W-1 -: HI_W] <= wrData[HI_W-1:0];
      if (wrAddr == REG_ADDR_W'(2)) stationQ[REG_W-1:0] <= wrData;
      for (int k = 0; k < HASH_REGS; k++) begin
        if (wrAddr == REG_ADDR_W'(HASH_BASE + k)) hashQ[k*REG_W +: REG_W] <= wrData;
      end
    end
  end
endmodule

// File: rtl/rx_dest_filter_ctrl.sv
module rx_dest_filter_ctrl
  import rx_dest_filter_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   byteValid,
  input  logic   daFirst,
  output dpCtl_t ctl
);
  logic [SLOT_W-1:0] cntQ;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot       = daFirst ? '0 : cntQ;
    ctl.step   = byteValid;
    ctl.seed   = byteValid && (slot == '0);
    ctl.finish = byteValid && (slot == SLOT_W'(ADDR_BYTES - 1));
    ctl.slot   = slot;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cntQ <= '0;
    else if (ctl.finish) cntQ <= '0;
    else if (byteValid)  cntQ <= slot + SLOT_W'(1);
  end
endmodule

// File: rtl/rx_dest_filter_dp.sv
module rx_dest_filter_dp
  import rx_dest_filter_pkg::*;
#(
  parameter int HASH_IDX_W = 6,
  localparam int HASH_BITS = 1 << HASH_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [7:0]           byteData,
  input  mode_t                mode,
  input  logic [ADDR_W-1:0]    station,
  input  logic [HASH_BITS-1:0] hashTable,
  output logic                 resultValid,
  output logic                 accept,
  output logic                 isMcast
);
  logic [CRC_W-1:0]                crcQ, crcNext;
  logic [ADDR_BYTES-1:0][7:0]      bytesQ, fullBytes;
  logic [ADDR_W-1:0]               addrVec;
  logic [HASH_IDX_W-1:0]           hashIdx;
  logic                            groupAddr, allOnes, stationHit, hashHit, decide;

  always_comb crcNext = crcByte(ctl.seed ? '1 : crcQ, byteData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ   <= '1;
      bytesQ <= '0;
    end else if (ctl.step) begin
      crcQ             <= crcNext;
      bytesQ[ctl.slot] <= byteData;
    end
  end

  // the final byte is taken straight from the input
  always_comb begin
    for (int i = 0; i < ADDR_BYTES; i++) begin
      fullBytes[i] = (i == ADDR_BYTES - 1) ? byteData : bytesQ[i];
      addrVec[(ADDR_BYTES-1-i)*8 +: 8] = fullBytes[i];
    end
    hashIdx    = crcNext[CRC_W-1 -: HASH_IDX_W];
    hashHit    = hashTable[hashIdx];
    groupAddr  = fullBytes[0][0];
    allOnes    = &addrVec;
    stationHit = (addrVec == station);
    if (mode.promisc)   decide = 1'b1;
    else if (allOnes)   decide = mode.bcastEn;
    else if (groupAddr) decide = mode.allMcast | (mode.hashEn & hashHit);
    else                decide = stationHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      accept      <= 1'b0;
      isMcast     <= 1'b0;
    end else begin
      resultValid <= ctl.finish;
      accept      <= ctl.finish & decide;
      isMcast     <= ctl.finish & groupAddr;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter int HASH_IDX_W = 6,
  parameter int REG_W      = 32,
  parameter int REG_ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic                  byteValid,
  input  logic                  daFirst,
  input  logic [7:0]            byteData,
  output logic                  resultValid,
  output logic                  accept,
  output logic                  isMcast
);
  localparam int HASH_BITS = 1 << HASH_IDX_W;

  mode_t                modeQ;
  logic [ADDR_W-1:0]    stationQ;
  logic [HASH_BITS-1:0] hashQ;
  dpCtl_t               ctl;
  logic                 promiscOn;

  assign promiscOn = modeQ.promisc;

  rx_dest_filter_regs #(.HASH_IDX_W(HASH_IDX_W), .REG_W(REG_W), .REG_ADDR_W(REG_ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .modeQ(modeQ), .stationQ(stationQ), .hashQ(hashQ));

  rx_dest_filter_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .daFirst(daFirst), .ctl(ctl));

  rx_dest_filter_dp #(.HASH_IDX_W(HASH_IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteData(byteData), .mode(modeQ),
    .station(stationQ), .hashTable(hashQ),
    .resultValid(resultValid), .accept(accept), .isMcast(isMcast));
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk (
  input logic clk,
  input logic rstN,
  input logic byteValid,
  input logic resultValid,
  input logic accept,
  input logic isMcast,
  input logic promiscOn
);
  // R2
  result_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(byteValid));
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  // R2
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (!accept && !isMcast));
  // R9
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && $past(promiscOn)) |-> accept);
endmodule

bind rx_dest_filter rx_dest_filter_chk uChk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .resultValid(resultValid),
  .accept(accept), .isMcast(isMcast), .promiscOn(promiscOn));

// File: tb/sim_rx_dest_filter.sv
`timescale 1ns/1ps
module sim_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        byteValid = 1'b0;
  logic        daFirst = 1'b0;
  logic [7:0]  byteData = '0;
  logic        resultValid, accept, isMcast;

  int checks = 0;
  int fails  = 0;

  // model of the register contents
  logic [3:0]  mMode = 4'b0001;   // bit0 bcast, bit1 allMcast, bit2 promisc, bit3 hashEn
  logic [47:0] mSt   = '0;
  logic [63:0] mHash = '0;

  always #2.5 clk = ~clk;

  rx_dest_filter u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .byteValid(byteValid), .daFirst(daFirst), .byteData(byteData),
    .resultValid(resultValid), .accept(accept), .isMcast(isMcast));

  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c = c ^ {24'h0, a[47-8*b -: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic logic expAccept(input logic [47:0] a);
    logic [5:0] idx;
    idx = refIdx(a);
    if (mMode[2]) return 1'b1;
    if (&a) return mMode[0];
    if (a[40]) return mMode[1] | (mMode[3] & mHash[idx]);
    return a == mSt;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      3'd0: mMode = d[3:0];
      3'd1: mSt[47:32] = d[15:0];
      3'd2: mSt[31:0] = d;
      3'd3: mHash[31:0] = d;
      3'd4: mHash[63:32] = d;
      default: ;
    endcase
  endtask

  task automatic setStation(input logic [47:0] s);
    wr(3'd1, {16'h0, s[47:32]});
    wr(3'd2, s[31:0]);
  endtask

  // sends one address; lateWr puts a register write on the sixth byte
  task automatic sendAddr(input logic [47:0] a, input bit gap, input string req,
                          input bit lateWr, input logic [2:0] wa, input logic [31:0] wd);
    logic expA;
    expA = expAccept(a);
    for (int i = 0; i < 6; i++) begin
      if (gap && i == 3) begin
        @(negedge clk); byteValid = 1'b0; daFirst = 1'b0;
      end
      @(negedge clk);
      byteValid = 1'b1; daFirst = (i == 0); byteData = a[47-8*i -: 8];
      if (lateWr && i == 5) begin
        regWrEn = 1'b1; regAddr = wa; regWrData = wd;
      end
    end
    @(negedge clk);
    byteValid = 1'b0; daFirst = 1'b0; regWrEn = 1'b0;
    if (lateWr) begin
      case (wa)
        3'd0: mMode = wd[3:0];
        3'd1: mSt[47:32] = wd[15:0];
        3'd2: mSt[31:0] = wd;
        3'd3: mHash[31:0] = wd;
        3'd4: mHash[63:32] = wd;
        default: ;
      endcase
    end
    chk(resultValid === 1'b1, {req, " R2 strobe"}, resultValid, 1);
    chk(accept === expA, {req, " accept"}, accept, expA);
    chk(isMcast === a[40], "R5 mcast flag", isMcast, a[40]);
    @(negedge clk);
    chk(resultValid === 1'b0 && accept === 1'b0, "R2 pulse ends", {resultValid, accept}, 0);
  endtask

  function automatic logic [47:0] mcastWithIdx(input bit high);
    logic [47:0] a;
    do begin
      a = {$urandom(), $urandom()};
      a[40] = 1'b1;
      a[0]  = 1'b0;
    end while (refIdx(a)[5] != high);
    return a;
  endfunction

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    logic [47:0] a, st;
    logic [5:0] idx;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(resultValid === 1'b0, "R1 resultValid", resultValid, 0);
    chk(accept === 1'b0 && isMcast === 1'b0, "R1 outputs", {accept, isMcast}, 0);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R1 default broadcast", 0, 0, 0);
    sendAddr(48'h0000_0000_0000, 0, "R1 station zero", 0, 0, 0);
    sendAddr(48'h0100_0000_0000, 0, "R1 hash off", 0, 0, 0);

    // R4 station match and layout
    st = 48'h0A1B_2C3D_4E5F;
    setStation(st);
    sendAddr(st, 0, "R4 exact", 0, 0, 0);
    for (int b = 0; b < 48; b += 7) sendAddr(st ^ (48'h1 << b), 0, "R4 one bit off", 0, 0, 0);
    sendAddr(st, 1, "R3 gap", 0, 0, 0);

    // R3 restart on daFirst
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byteValid = 1'b1; daFirst = (i == 0); byteData = 8'hC3;
    end
    sendAddr(st, 0, "R3 restart", 0, 0, 0);

    // R6 broadcast disabled, other enables do not rescue it
    wr(3'd0, 32'h0000_000A);
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R6 bcast off", 0, 0, 0);
    wr(3'd0, 32'h0000_0001);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R6 bcast on", 0, 0, 0);

    // R7 all-multicast
    wr(3'd3, 0); wr(3'd4, 0);
    wr(3'd0, 32'h0000_0002);
    sendAddr(48'h0300_5E00_0001, 0, "R7 allmcast", 0, 0, 0);
    sendAddr(st ^ 48'h1, 0, "R7 unicast unaffected", 0, 0, 0);

    // R8 hash, both table halves
    for (int h = 0; h < 2; h++) begin
      a = mcastWithIdx(h[0]);
      idx = refIdx(a);
      wr(3'd0, 32'h0000_0008);
      wr(3'd3, 0); wr(3'd4, 0);
      if (idx >= 32) wr(3'd4, 32'h1 << (idx - 32)); else wr(3'd3, 32'h1 << idx);
      sendAddr(a, 0, "R8 hash hit", 0, 0, 0);
      if (idx >= 32) wr(3'd4, ~(32'h1 << (idx - 32))); else wr(3'd3, ~(32'h1 << idx));
      wr(idx >= 32 ? 3'd3 : 3'd4, 32'hFFFF_FFFF);
      sendAddr(a, 0, "R8 hash miss", 0, 0, 0);
      wr(idx >= 32 ? 3'd4 : 3'd3, 32'hFFFF_FFFF);
      wr(3'd0, 32'h0000_0000);
      sendAddr(a, 0, "R8 hash disabled", 0, 0, 0);
    end

    // R9 promiscuous
    wr(3'd0, 32'h0000_0004);
    sendAddr(48'h1234_5678_9ABC, 0, "R9 promisc unicast", 0, 0, 0);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R9 promisc bcast", 0, 0, 0);

    // R10 write on the deciding cycle
    wr(3'd0, 32'h0000_0000);
    setStation(st);
    sendAddr(st, 0, "R10 old station used", 1, 3'd2, 32'h0);
    sendAddr(st, 0, "R10 new station applies", 0, 0, 0);
    wr(3'd0, 32'h0000_0000);
    sendAddr(48'h1234_5678_9ABC, 0, "R10 old mode used", 1, 3'd0, 32'h4);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      int kind;
      if ($urandom_range(0, 3) == 0) wr(3'd0, $urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0) wr(3'($urandom_range(3, 4)), $urandom());
      if ($urandom_range(0, 9) == 0) setStation({$urandom(), $urandom()});
      kind = $urandom_range(0, 4);
      case (kind)
        0: a = mSt;
        1: a = mSt ^ (48'h1 << $urandom_range(0, 47));
        2: a = 48'hFFFF_FFFF_FFFF;
        3: begin a = {$urandom(), $urandom()}; a[40] = 1'b1; end
        default: a = {$urandom(), $urandom()};
      endcase
      sendAddr(a, $urandom_range(0, 1), kind == 2 ? "R6 random" :
               (kind == 3 ? "R7/R8 random" : "R4/R9 random"), 0, 0, 0);
    end
    finishRun();
  end
endmodule